// File: doc/BRIEF.md
# Indirect Branch Path History Buffer

This block keeps, for one hardware thread, an ordered record of recently seen indirect branches. Each record holds the branch address, its target and the sequence number the front end assigned to it. Records are stored in a circular buffer. New branches join at the young end. Misspeculation removes records by comparing sequence numbers. Retirement moves a head marker forward, but committed records stay until enough of them exist to fill the hashing window. A target predictor uses the window outputs to fold the most recent targets into its set index. For the target-update path, the youngest record can be left out of the window. Multi-threaded front ends instantiate one copy per thread.

Each cycle performs at most one operation, chosen by a fixed priority among the four request inputs. The window outputs are combinational from the stored state and the skip input. A request therefore shows on the window at the first clock edge after it is presented.

Top module: `phb_path_history`

## Requirements
- R1: After reset the buffer is empty: `occ_o` = 0, `head_idx_o` = 0, and every `win_valid` bit is 0 with zeroed `win_br`/`win_tgt` slots.
- R2: A record request stores {`rec_br`, `rec_tgt`, `rec_seq`} as the new youngest entry, and `occ_o` grows by one when the buffer is not full.
- R3: A record into a full buffer (`occ_o` = D) drops the oldest entry and keeps `occ_o` at D. If the head index was nonzero, it decreases by one so that it still names the same entry.
- R4: A squash with value S finds the oldest entry whose sequence number is greater than S (unsigned compare) and removes it together with every younger entry. If no entry exceeds S, nothing changes. The head index is never altered by a squash.
- R5: A commit on an empty buffer changes nothing.
- R6: A commit with value S acts only if the head index is below `occ_o` and the sequence number of the entry at that age (age 0 = oldest) is at most S. If the head index is at least P, the oldest entry is dropped and the head index is kept. Otherwise the head index increments. In every other case nothing changes.
- R7: A retarget request overwrites the target of the youngest entry with `rt_tgt` and leaves its branch address, sequence number, `occ_o` and the head index unchanged. On an empty buffer it does nothing.
- R8: Window slot k (bits [k*AW +: AW]) shows the (k+`win_skip`)-th youngest entry, where k = 0 is the youngest. A slot is valid only when that entry exists. Invalid slots read as zero.
- R9: When several requests arrive together, only one acts, in the order squash, retarget, commit, record. The others are ignored for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rec_valid | input | 1 | Append a new youngest entry |
| rec_br | input | AW | Branch address to append |
| rec_tgt | input | AW | Target address to append |
| rec_seq | input | SW | Sequence number to append |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SW | Squash boundary; entries from the oldest one above it onward are removed |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | SW | Committed sequence number |
| rt_valid | input | 1 | Retarget the youngest entry |
| rt_tgt | input | AW | Resolved target for the youngest entry |
| win_skip | input | 1 | Window starts one entry older, skipping the youngest |
| win_valid | output | P | Per-slot valid, slot 0 youngest |
| win_br | output | P*AW | Branch addresses of the window slots |
| win_tgt | output | P*AW | Target addresses of the window slots |
| occ_o | output | $clog2(D+1) | Number of stored entries |
| head_idx_o | output | $clog2(D+1) | Head index, counted as an age from the oldest entry |

## Verification
The bench builds the block with P = 3, D = 16, AW = 12 and SW = 8. A path length that is not a power of two exercises the head-index threshold away from a bit boundary. The depth is small enough that the buffer fills and wraps many times, so every pointer value is visited, and so are the full-buffer drop and the head-index decrement. The 8-bit sequence numbers wrap during the long sweep. The bench compares every squash and commit decision against an arithmetic model, including decisions on wrapped values, and it reads both window alignments after every operation.

// File: rtl/phb_pkg.sv
package phb_pkg;

  // Operation chosen for the current cycle, after priority resolution.
  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_SQUASH   = 3'd1,
    OP_RETARGET = 3'd2,
    OP_COMMIT   = 3'd3,
    OP_RECORD   = 3'd4
  } phb_op_e;

  // Position of an entry relative to the oldest stored entry.
  function automatic logic [15:0] age_to_slot(input logic [15:0] head,
                                              input logic [15:0] age,
                                              input int unsigned depth);
    age_to_slot = (head + age) % depth[15:0];
  endfunction

endpackage

// File: rtl/phb_squash_find.sv
// Parallel search for the oldest stored entry whose sequence number lies
// beyond the squash boundary.
module phb_squash_find #(
  parameter int D  = 16,
  parameter int SW = 10,
  localparam int PW = $clog2(D),
  localparam int CW = $clog2(D + 1)
) (
  input  logic [PW-1:0]   head,
  input  logic [CW-1:0]   occ,
  input  logic [D*SW-1:0] seq_flat,
  input  logic [SW-1:0]   cut_seq,
  output logic            found,
  output logic [CW-1:0]   cut_age
);

  logic [D-1:0] younger;

  // One comparator per age; age 0 is the oldest entry.
  for (genvar a = 0; a < D; a++) begin : g_cmp
    logic [PW-1:0] slot;
    logic [SW-1:0] slot_seq;
    assign slot     = head + PW'(a);
    assign slot_seq = seq_flat[slot*SW +: SW];
    assign younger[a] = (CW'(a) < occ) && (slot_seq > cut_seq);
  end

  // The lowest matching age wins.
  always_comb begin
    found   = 1'b0;
    cut_age = '0;
    for (int a = D - 1; a >= 0; a--) begin
      if (younger[a]) begin
        found   = 1'b1;
        cut_age = CW'(a);
      end
    end
  end

endmodule

// File: rtl/phb_window.sv
// Youngest-first read window over the stored targets and branch addresses.
module phb_window #(
  parameter int D  = 16,
  parameter int P  = 4,
  parameter int AW = 16,
  localparam int PW = $clog2(D),
  localparam int CW = $clog2(D + 1)
) (
  input  logic [PW-1:0]   head,
  input  logic [CW-1:0]   occ,
  input  logic            skip,
  input  logic [D*AW-1:0] br_flat,
  input  logic [D*AW-1:0] tg_flat,
  output logic [P-1:0]    vld,
  output logic [P*AW-1:0] br_o,
  output logic [P*AW-1:0] tg_o
);

  for (genvar k = 0; k < P; k++) begin : g_slot
    logic [CW-1:0] need;
    logic [CW-1:0] age;
    logic [PW-1:0] slot;
    logic          here;
    assign need = CW'(k + 1) + CW'(skip);
    assign here = (occ >= need);
    assign age  = occ - need;
    assign slot = head + PW'(age);
    assign vld[k] = here;
    assign br_o[k*AW +: AW] = here ? br_flat[slot*AW +: AW] : '0;
    assign tg_o[k*AW +: AW] = here ? tg_flat[slot*AW +: AW] : '0;
  end

endmodule

// File: rtl/phb_ctrl.sv
// Pointer, occupancy and head-index control with request priority.
module phb_ctrl
  import phb_pkg::*;
#(
  parameter int D = 16,
  parameter int P = 4,
  parameter int SW = 10,
  localparam int PW = $clog2(D),
  localparam int CW = $clog2(D + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_v,
  input  logic          sq_v,
  input  logic          cm_v,
  input  logic          rt_v,
  input  logic          cut_found,
  input  logic [CW-1:0] cut_age,
  input  logic [SW-1:0] head_seq,
  input  logic [SW-1:0] cm_seq,
  output logic [PW-1:0] head,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] hidx,
  output logic          wr_en,
  output logic [PW-1:0] wr_slot,
  output logic          rt_en,
  output logic [PW-1:0] rt_slot
);

  localparam logic [CW-1:0] FULL  = CW'(D);
  localparam logic [CW-1:0] PLIM  = CW'(P);

  phb_op_e       op;
  logic [PW-1:0] head_n;
  logic [CW-1:0] occ_n;
  logic [CW-1:0] hidx_n;
  logic          st_en;

  always_comb begin
    if (sq_v)       op = OP_SQUASH;
    else if (rt_v)  op = OP_RETARGET;
    else if (cm_v)  op = OP_COMMIT;
    else if (rec_v) op = OP_RECORD;
    else            op = OP_IDLE;
  end

  always_comb begin
    head_n  = head;
    occ_n   = occ;
    hidx_n  = hidx;
    wr_en   = 1'b0;
    wr_slot = head + PW'(occ);
    rt_en   = 1'b0;
    rt_slot = head + PW'(occ - CW'(1));
    unique case (op)
      OP_SQUASH: begin
        if (cut_found) occ_n = cut_age;
      end
      OP_RETARGET: begin
        rt_en = (occ != '0);
      end
      OP_COMMIT: begin
        if ((hidx < occ) && (head_seq <= cm_seq)) begin
          if (hidx >= PLIM) begin
            head_n = head + PW'(1);
            occ_n  = occ - CW'(1);
          end else begin
            hidx_n = hidx + CW'(1);
          end
        end
      end
      OP_RECORD: begin
        wr_en = 1'b1;
        if (occ == FULL) begin
          head_n = head + PW'(1);
          if (hidx != '0) hidx_n = hidx - CW'(1);
        end else begin
          occ_n = occ + CW'(1);
        end
      end
      default: ;
    endcase
  end

  assign st_en = (op != OP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      occ  <= '0;
      hidx <= '0;
    end else if (st_en) begin
      head <= head_n;
      occ  <= occ_n;
      hidx <= hidx_n;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL); // R3

  AST_APPEND_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_v && !sq_v && !rt_v && !cm_v && occ != FULL)
      |=> (occ == $past(occ) + CW'(1))); // R2

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_v && !sq_v && !rt_v && !cm_v && occ == FULL)
      |=> (occ == FULL)); // R3

  AST_SQUASH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    sq_v |=> (occ <= $past(occ) && hidx == $past(hidx))); // R4

  AST_COMMIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_v && !sq_v && !rt_v && occ == '0)
      |=> (occ == '0 && $stable(hidx))); // R5

  AST_RETARGET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_v && !sq_v) |=> ($stable(occ) && $stable(head) && $stable(hidx))); // R9

endmodule

// File: rtl/phb_path_history.sv
// Per-thread path history buffer: storage, squash search, window and control.
module phb_path_history #(
  parameter int AW = 16,
  parameter int SW = 10,
  parameter int D  = 16,
  parameter int P  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rec_valid,
  input  logic [AW-1:0]          rec_br,
  input  logic [AW-1:0]          rec_tgt,
  input  logic [SW-1:0]          rec_seq,
  input  logic                   sq_valid,
  input  logic [SW-1:0]          sq_seq,
  input  logic                   cm_valid,
  input  logic [SW-1:0]          cm_seq,
  input  logic                   rt_valid,
  input  logic [AW-1:0]          rt_tgt,
  input  logic                   win_skip,
  output logic [P-1:0]           win_valid,
  output logic [P*AW-1:0]        win_br,
  output logic [P*AW-1:0]        win_tgt,
  output logic [$clog2(D+1)-1:0] occ_o,
  output logic [$clog2(D+1)-1:0] head_idx_o
);

  localparam int PW = $clog2(D);
  localparam int CW = $clog2(D + 1);

  logic [1:0]      rst_pipe;
  logic            rst_i;
  logic [PW-1:0]   head;
  logic [CW-1:0]   occ;
  logic [CW-1:0]   hidx;
  logic            wr_en;
  logic [PW-1:0]   wr_slot;
  logic            rt_en;
  logic [PW-1:0]   rt_slot;
  logic            cut_found;
  logic [CW-1:0]   cut_age;
  logic [SW-1:0]   head_seq;
  logic [PW-1:0]   head_slot;
  logic [D*AW-1:0] br_flat;
  logic [D*AW-1:0] tg_flat;
  logic [D*SW-1:0] seq_flat;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  // Entry storage: one register set per slot, written only when addressed.
  for (genvar e = 0; e < D; e++) begin : g_ent
    logic [AW-1:0] br_q;
    logic [AW-1:0] tg_q;
    logic [SW-1:0] sq_q;
    logic          rec_hit;
    logic          rt_hit;
    assign rec_hit = wr_en && (wr_slot == PW'(e));
    assign rt_hit  = rt_en && (rt_slot == PW'(e));
    always_ff @(posedge clk) begin
      if (rec_hit) begin
        br_q <= rec_br;
        tg_q <= rec_tgt;
        sq_q <= rec_seq;
      end else if (rt_hit) begin
        tg_q <= rt_tgt;
      end
    end
    assign br_flat[e*AW +: AW]  = br_q;
    assign tg_flat[e*AW +: AW]  = tg_q;
    assign seq_flat[e*SW +: SW] = sq_q;
  end

  assign head_slot = head + PW'(hidx);
  assign head_seq  = seq_flat[head_slot*SW +: SW];

  phb_squash_find #(.D(D), .SW(SW)) u_find (
    .head     (head),
    .occ      (occ),
    .seq_flat (seq_flat),
    .cut_seq  (sq_seq),
    .found    (cut_found),
    .cut_age  (cut_age)
  );

  phb_ctrl #(.D(D), .P(P), .SW(SW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i),
    .rec_v     (rec_valid),
    .sq_v      (sq_valid),
    .cm_v      (cm_valid),
    .rt_v      (rt_valid),
    .cut_found (cut_found),
    .cut_age   (cut_age),
    .head_seq  (head_seq),
    .cm_seq    (cm_seq),
    .head      (head),
    .occ       (occ),
    .hidx      (hidx),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .rt_en     (rt_en),
    .rt_slot   (rt_slot)
  );

  phb_window #(.D(D), .P(P), .AW(AW)) u_win (
    .head    (head),
    .occ     (occ),
    .skip    (win_skip),
    .br_flat (br_flat),
    .tg_flat (tg_flat),
    .vld     (win_valid),
    .br_o    (win_br),
    .tg_o    (win_tgt)
  );

  assign occ_o      = occ;
  assign head_idx_o = hidx;

  AST_WIN_YOUNGEST_VALID: assert property (@(posedge clk) disable iff (!rst_i)
    (occ > CW'(win_skip)) |-> win_valid[0]); // R8

  AST_CUT_INSIDE: assert property (@(posedge clk) disable iff (!rst_i)
    (sq_valid && cut_found) |=> (occ_o < $past(occ_o))); // R4

endmodule

// File: tb/phb_path_history_test.sv
`timescale 1ns/1ps
module phb_path_history_test;

  localparam int AW = 12;
  localparam int SW = 8;
  localparam int D  = 16;
  localparam int P  = 3;
  localparam int CW = $clog2(D + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rec_valid = 1'b0, sq_valid = 1'b0, cm_valid = 1'b0, rt_valid = 1'b0;
  logic [AW-1:0]   rec_br = '0, rec_tgt = '0, rt_tgt = '0;
  logic [SW-1:0]   rec_seq = '0, sq_seq = '0, cm_seq = '0;
  logic            win_skip = 1'b0;
  logic [P-1:0]    win_valid;
  logic [P*AW-1:0] win_br, win_tgt;
  logic [CW-1:0]   occ_o, head_idx_o;

  int errors = 0;
  int checks = 0;

  // Reference state, indexed by age (0 = oldest).
  logic [AW-1:0] m_br [D];
  logic [AW-1:0] m_tg [D];
  logic [SW-1:0] m_sq [D];
  int m_cnt = 0;
  int m_hidx = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [SW-1:0] next_seq = '0;

  always #4 clk = ~clk;

  phb_path_history #(.AW(AW), .SW(SW), .D(D), .P(P)) uut (
    .clk(clk), .rst_n(rst_n),
    .rec_valid(rec_valid), .rec_br(rec_br), .rec_tgt(rec_tgt), .rec_seq(rec_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq),
    .cm_valid(cm_valid), .cm_seq(cm_seq),
    .rt_valid(rt_valid), .rt_tgt(rt_tgt),
    .win_skip(win_skip),
    .win_valid(win_valid), .win_br(win_br), .win_tgt(win_tgt),
    .occ_o(occ_o), .head_idx_o(head_idx_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, "occupancy", int'(occ_o), m_cnt);
    check(req, "head index", int'(head_idx_o), m_hidx);
    for (int s = 0; s < 2; s++) begin
      win_skip = s[0];
      #1;
      for (int k = 0; k < P; k++) begin
        int age;
        bit here;
        here = (m_cnt >= k + s + 1);
        age  = m_cnt - k - s - 1;
        check(req, "slot valid", int'(win_valid[k]), int'(here));
        check(req, "slot branch", int'(win_br[k*AW +: AW]), here ? int'(m_br[age]) : 0);
        check(req, "slot target", int'(win_tgt[k*AW +: AW]), here ? int'(m_tg[age]) : 0);
      end
    end
    win_skip = 1'b0;
  endtask

  task automatic drop_oldest();
    for (int i = 0; i < D - 1; i++) begin
      m_br[i] = m_br[i+1];
      m_tg[i] = m_tg[i+1];
      m_sq[i] = m_sq[i+1];
    end
  endtask

  // Model update following R2..R7 with the R9 priority.
  task automatic model(input bit r, input bit s, input bit c, input bit t,
                       input logic [AW-1:0] br, input logic [AW-1:0] tg,
                       input logic [AW-1:0] rtg, input logic [SW-1:0] rs,
                       input logic [SW-1:0] ss, input logic [SW-1:0] cs);
    if (s) begin
      for (int a = 0; a < m_cnt; a++) begin
        if (m_sq[a] > ss) begin
          m_cnt = a;
          break;
        end
      end
    end else if (t) begin
      if (m_cnt > 0) m_tg[m_cnt-1] = rtg;
    end else if (c) begin
      if (m_hidx < m_cnt && m_sq[m_hidx] <= cs) begin
        if (m_hidx >= P) begin
          drop_oldest();
          m_cnt--;
        end else begin
          m_hidx++;
        end
      end
    end else if (r) begin
      if (m_cnt == D) begin
        drop_oldest();
        m_cnt--;
        if (m_hidx > 0) m_hidx--;
      end
      m_br[m_cnt] = br;
      m_tg[m_cnt] = tg;
      m_sq[m_cnt] = rs;
      m_cnt++;
    end
  endtask

  task automatic apply(input bit r, input bit s, input bit c, input bit t,
                       input logic [AW-1:0] br, input logic [AW-1:0] tg,
                       input logic [AW-1:0] rtg, input logic [SW-1:0] rs,
                       input logic [SW-1:0] ss, input logic [SW-1:0] cs,
                       input string req);
    rec_valid = r; sq_valid = s; cm_valid = c; rt_valid = t;
    rec_br = br; rec_tgt = tg; rt_tgt = rtg;
    rec_seq = rs; sq_seq = ss; cm_seq = cs;
    @(posedge clk);
    model(r, s, c, t, br, tg, rtg, rs, ss, cs);
    @(negedge clk);
    rec_valid = 1'b0; sq_valid = 1'b0; cm_valid = 1'b0; rt_valid = 1'b0;
    compare(req);
  endtask

  task automatic rec(input logic [SW-1:0] sq, input string req);
    apply(1, 0, 0, 0, AW'(12'h100 + sq), AW'(12'h800 + 3 * sq), '0, sq, '0, '0, req);
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1");

    // Empty buffer: commit and retarget leave everything as is.
    apply(0, 0, 1, 0, '0, '0, '0, '0, '0, 8'hFF, "R5");
    apply(0, 0, 0, 1, '0, '0, 12'h5A5, '0, '0, '0, "R7");

    // Appends and window alignment.
    for (int i = 1; i <= 5; i++) rec(SW'(i), "R2_R8");
    apply(0, 0, 0, 1, '0, '0, 12'h777, '0, '0, '0, "R7");

    // Commit: head index climbs to P, then oldest entries drop.
    apply(0, 0, 1, 0, '0, '0, '0, '0, '0, 8'd0, "R6");
    for (int i = 1; i <= 5; i++) apply(0, 0, 1, 0, '0, '0, '0, '0, '0, 8'd5, "R6");

    // Squash beyond every entry, then a squash in the middle.
    apply(0, 1, 0, 0, '0, '0, '0, '0, 8'd9, '0, "R4");
    for (int i = 6; i <= 10; i++) rec(SW'(i), "R2");
    apply(0, 1, 0, 0, '0, '0, '0, '0, 8'd7, '0, "R4");

    // Fill past capacity.
    for (int i = 8; i <= 30; i++) rec(SW'(i), "R3");

    // Priority among simultaneous requests.
    apply(1, 1, 1, 1, 12'hABC, 12'hDEF, 12'h123, 8'd40, 8'd25, 8'd99, "R9");
    apply(1, 0, 1, 1, 12'hABC, 12'hDEF, 12'h321, 8'd41, '0, 8'd99, "R9");
    apply(1, 0, 1, 0, 12'hABC, 12'hDEF, '0, 8'd42, '0, 8'd99, "R9");

    // Long pseudo-random sweep.
    next_seq = 8'd26;
    for (int n = 0; n < 6000; n++) begin
      int sel;
      logic [SW-1:0] sv, cv;
      lfsr = step(lfsr);
      sel = int'(lfsr[3:0]);
      sv = (m_cnt > 0) ? m_sq[int'(lfsr[11:4]) % m_cnt] - SW'(lfsr[12]) : SW'(lfsr[11:4]);
      cv = (m_cnt > 0) ? m_sq[(m_hidx < m_cnt) ? m_hidx : m_cnt - 1] - SW'(lfsr[13] & lfsr[14])
                       : SW'(lfsr[11:4]);
      if (sel < ((n < 3000) ? 7 : 5)) begin
        apply(1, 0, 0, 0, AW'(lfsr), AW'({lfsr[7:0], lfsr[15:12]}), '0, next_seq, '0, '0, "R2_R3");
        next_seq = next_seq + 8'd1;
      end else if (sel < 10) begin
        apply(0, 0, 1, 0, '0, '0, '0, '0, '0, cv, "R6");
      end else if (sel == 10) begin
        apply(0, 1, 0, 0, '0, '0, '0, '0, sv, '0, "R4");
        next_seq = sv + 8'd1;
      end else if (sel == 11) begin
        apply(0, 0, 0, 1, '0, '0, AW'(lfsr ^ 16'h3C3C), '0, '0, '0, "R7");
      end else if (sel == 12) begin
        apply(lfsr[4], lfsr[5], lfsr[6], lfsr[7], AW'(lfsr), AW'(~lfsr), AW'(lfsr >> 3),
              next_seq, sv, cv, "R9");
        if (lfsr[5]) next_seq = sv + 8'd1;
        else if (!lfsr[7] && !lfsr[6] && lfsr[4]) next_seq = next_seq + 8'd1;
      end else begin
        apply(0, 0, 0, 0, '0, '0, '0, '0, '0, '0, "R8");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule